// File: doc/BRIEF.md
# USB Host Electrical Test-Mode Sequencer

This block guards the entry into the electrical test modes of a USB 2.0 host port. Software programs it through a small register write port: one address carries four control bits (host select, pull-down enable, module enable, activate) and a second address carries a 4-bit test selector. The block accepts only writes that follow the legal setup or re-selection order. It rejects any other write and records it in a sticky sequence-error flag. The port is left in its existing state.

While a test runs, the block drives a test-waveform enable and a high-speed termination enable. It also drives a periodic start-of-frame strobe, whose period is a parameter and defaults to one 125 µs microframe at 60 MHz. A disconnect-detect pulse is handled according to the selected code. Once a test has been activated, the block stays in a locked test condition until reset; no register write brings it back to normal operation. A selector write is also refused while any pipe's handshake state is not NAK.

Top module: `usb_host_test_seq`

## Requirements
- R1: After reset the selector reads 0000 and every output flag, enable and strobe is 0.
- R2: A control write (address 0; bit0 host select, bit1 pull-down, bit2 module enable, bit3 activate) is accepted only in this order: 0011 from idle, then 0111, then a selector write, then 1111. Any other control write is rejected, leaves the outputs unchanged and sets the sticky sequence error.
- R3: A selector write (address 1) is accepted only directly after the module-enable step. In any other state it is rejected, the selector keeps its value and the sequence error is set.
- R4: The waveform enable is 1 exactly while pull-down and activate are both set, from the cycle after the accepted activate write.
- R5: The high-speed termination enable turns on in the cycle after an accepted selector write and stays on until reset.
- R6: While a test is active, the selector can be changed by writing 0011, then 0111, then the new selector, then 1111.
- R7: Pipe handshake states are 2-bit fields with 00 meaning NAK. A selector write with any pipe not at NAK is rejected: selector and termination are unchanged and the sticky NAK error is set.
- R8: While activate is set and the selector is not 1011, a one-cycle SOF strobe occurs every SOF_PERIOD cycles, the first one SOF_PERIOD cycles after activation.
- R9: With selector 1011 no SOF strobe is produced, even while activate is set.
- R10: With selector 1101 a disconnect pulse is ignored: activate stays set, no interrupt is raised and SOF strobes continue.
- R11: With any other selector, a disconnect pulse while active clears activate and raises a one-cycle interrupt; writing 1111 again re-activates.
- R12: The locked flag rises on the first activation and stays 1 until reset. Writing 0000 while active or paused clears all bits into a locked idle state. In that state every write is rejected as a sequence error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control bits, 1 = test selector |
| wr_data | input | 4 | Write data |
| pipe_pid | input | 2*NUM_PIPES | Handshake state per pipe, 00 = NAK |
| dtch_pulse | input | 1 | Disconnect-detect pulse |
| sel_out | output | 4 | Current test selector |
| wave_en | output | 1 | Test waveform enable |
| hs_term_en | output | 1 | High-speed termination enable |
| sof_strobe | output | 1 | Start-of-frame strobe |
| dtch_irq | output | 1 | Disconnect interrupt pulse |
| seq_err | output | 1 | Sticky sequence-error flag |
| nak_err | output | 1 | Sticky pipe-not-NAK error flag |
| test_locked | output | 1 | Test has run; reset required |

## Verification
The bench builds the block with SOF_PERIOD set to 8 and NUM_PIPES set to 3. The short period lets a 40-cycle window hold exactly five strobes, so both spacing and first-strobe delay show up in a strobe count. Three pipes make a single non-NAK pipe in the middle of the vector visible to the NAK scan. The default period of 7500 cycles would place the strobe count beyond a compact run.

// File: rtl/usbt_pkg.sv
package usbt_pkg;
  localparam int SEL_W = 4;
  localparam int PID_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PREP, ST_EN, ST_SEL, ST_ACT, ST_PAUSE, ST_LOCK
  } seq_state_t;

  localparam logic [SEL_W-1:0] CODE_SE0_NAK  = 4'b1011;
  localparam logic [SEL_W-1:0] CODE_FORCE_EN = 4'b1101;
  localparam logic [PID_W-1:0] PID_NAK       = 2'b00;

  localparam logic [3:0] CTRL_OFF  = 4'b0000;
  localparam logic [3:0] CTRL_PREP = 4'b0011;
  localparam logic [3:0] CTRL_EN   = 4'b0111;
  localparam logic [3:0] CTRL_RUN  = 4'b1111;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_SEL  = 1'b1;
endpackage

// File: rtl/usbt_nak_scan.sv
module usbt_nak_scan
  import usbt_pkg::*;
#(
  parameter int NUM_PIPES = 4
) (
  input  logic [NUM_PIPES*PID_W-1:0] pids,
  output logic                       all_nak
);
  logic [NUM_PIPES-1:0] is_nak;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    assign is_nak[p] = (pids[p*PID_W +: PID_W] == PID_NAK);
  end

  assign all_nak = &is_nak;
endmodule

// File: rtl/usbt_seq_ctrl.sv
module usbt_seq_ctrl
  import usbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [SEL_W-1:0] wr_data,
  input  logic             all_nak,
  input  logic             dtch_clr,
  output logic [SEL_W-1:0] sel_o,
  output logic             act_o,
  output logic             term_o,
  output logic             locked_o,
  output logic             seq_err_o,
  output logic             nak_err_o
);
  seq_state_t       state_q, state_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             term_q, term_d;
  logic             lock_q, lock_d;
  logic             serr_q, serr_d;
  logic             nerr_q, nerr_d;

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    term_d  = term_q;
    serr_d  = serr_q;
    nerr_d  = nerr_q;
    if (dtch_clr && state_q == ST_ACT) begin
      state_d = ST_SEL;
    end else if (wr_en) begin
      if (wr_addr == ADDR_SEL) begin
        if (state_q == ST_EN) begin
          if (all_nak) begin
            sel_d   = wr_data;
            term_d  = 1'b1;
            state_d = ST_SEL;
          end else begin
            nerr_d = 1'b1;
          end
        end else begin
          serr_d = 1'b1;
        end
      end else begin
        case (state_q)
          ST_IDLE:  if (wr_data == CTRL_PREP) state_d = ST_PREP; else serr_d = 1'b1;
          ST_PREP:  if (wr_data == CTRL_EN)   state_d = ST_EN;   else serr_d = 1'b1;
          ST_SEL:   if (wr_data == CTRL_RUN)  state_d = ST_ACT;  else serr_d = 1'b1;
          ST_ACT: begin
            if (wr_data == CTRL_PREP)     state_d = ST_PAUSE;
            else if (wr_data == CTRL_OFF) state_d = ST_LOCK;
            else                          serr_d  = 1'b1;
          end
          ST_PAUSE: begin
            if (wr_data == CTRL_EN)       state_d = ST_EN;
            else if (wr_data == CTRL_OFF) state_d = ST_LOCK;
            else                          serr_d  = 1'b1;
          end
          default:  serr_d = 1'b1;
        endcase
      end
    end
    lock_d = lock_q | (state_d == ST_ACT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      term_q  <= 1'b0;
      lock_q  <= 1'b0;
      serr_q  <= 1'b0;
      nerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      term_q  <= term_d;
      lock_q  <= lock_d;
      serr_q  <= serr_d;
      nerr_q  <= nerr_d;
    end
  end

  assign sel_o     = sel_q;
  assign act_o     = (state_q == ST_ACT);
  assign term_o    = term_q;
  assign locked_o  = lock_q;
  assign seq_err_o = serr_q;
  assign nak_err_o = nerr_q;

  assert_locked_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  assert_lock_rejects_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && wr_en) |=> (state_q == ST_LOCK && serr_q));
  assert_term_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    term_q |=> term_q);
  assert_act_after_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |-> term_q);
  assert_nak_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_SEL && !all_nak) |=> $stable(sel_q) && nerr_q == (nerr_q | $past(state_q == ST_EN)));
endmodule

// File: rtl/usbt_sof_gen.sv
module usbt_sof_gen #(
  parameter int SOF_PERIOD = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic strobe
);
  localparam int CNT_W = (SOF_PERIOD > 2) ? $clog2(SOF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SOF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else if (!run) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q    <= '0;
      strobe_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      strobe_q <= 1'b0;
    end
  end

  assign strobe = strobe_q;

  assert_sof_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
  assert_sof_needs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> $past(run));
endmodule

// File: rtl/usbt_dtch_guard.sv
module usbt_dtch_guard
  import usbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dtch_in,
  input  logic             act,
  input  logic [SEL_W-1:0] sel,
  output logic             clr,
  output logic             irq
);
  logic irq_q;

  assign clr = dtch_in && act && (sel != CODE_FORCE_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= clr;
  end

  assign irq = irq_q;

  assert_force_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(sel) != CODE_FORCE_EN));
  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
endmodule

// File: rtl/usb_host_test_seq.sv
module usb_host_test_seq
  import usbt_pkg::*;
#(
  parameter int NUM_PIPES  = 4,
  parameter int SOF_PERIOD = 7500
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_addr,
  input  logic [3:0]                 wr_data,
  input  logic [NUM_PIPES*PID_W-1:0] pipe_pid,
  input  logic                       dtch_pulse,
  output logic [3:0]                 sel_out,
  output logic                       wave_en,
  output logic                       hs_term_en,
  output logic                       sof_strobe,
  output logic                       dtch_irq,
  output logic                       seq_err,
  output logic                       nak_err,
  output logic                       test_locked
);
  logic all_nak, act, dtch_clr;
  logic [SEL_W-1:0] sel;

  usbt_nak_scan #(.NUM_PIPES(NUM_PIPES)) u_nak (
    .pids(pipe_pid), .all_nak(all_nak));

  usbt_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .all_nak(all_nak), .dtch_clr(dtch_clr),
    .sel_o(sel), .act_o(act), .term_o(hs_term_en), .locked_o(test_locked),
    .seq_err_o(seq_err), .nak_err_o(nak_err));

  usbt_sof_gen #(.SOF_PERIOD(SOF_PERIOD)) u_sof (
    .clk(clk), .rst_n(rst_n), .run(act && (sel != CODE_SE0_NAK)),
    .strobe(sof_strobe));

  usbt_dtch_guard u_dtch (
    .clk(clk), .rst_n(rst_n), .dtch_in(dtch_pulse), .act(act), .sel(sel),
    .clr(dtch_clr), .irq(dtch_irq));

  assign sel_out = sel;
  assign wave_en = act;

  assert_no_sof_se0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CODE_SE0_NAK && $past(sel == CODE_SE0_NAK)) |-> !sof_strobe);
  assert_wave_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wave_en) |-> $past(wr_en && wr_addr == ADDR_CTRL && wr_data == CTRL_RUN));
endmodule

// File: tb/sim_usb_host_test_seq.sv
module sim_usb_host_test_seq;
  localparam int NP  = 3;
  localparam int PER = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_addr = 1'b0;
  logic [3:0]    wr_data = '0;
  logic [NP*2-1:0] pipe_pid = '0;
  logic          dtch_pulse = 1'b0;
  logic [3:0]    sel_out;
  logic          wave_en, hs_term_en, sof_strobe, dtch_irq, seq_err, nak_err, test_locked;

  usb_host_test_seq #(.NUM_PIPES(NP), .SOF_PERIOD(PER)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pipe_pid(pipe_pid), .dtch_pulse(dtch_pulse), .sel_out(sel_out),
    .wave_en(wave_en), .hs_term_en(hs_term_en), .sof_strobe(sof_strobe),
    .dtch_irq(dtch_irq), .seq_err(seq_err), .nak_err(nak_err),
    .test_locked(test_locked));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // [15] addr, [14:11] data, [10] one pipe not NAK,
  // [9] wave, [8] term, [7] locked, [6] seq_err, [5] nak_err, [4:1] sel
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 4'b0011, 1'b0, 5'b00000, 4'h0, 1'b0},
    {1'b0, 4'b0111, 1'b0, 5'b00000, 4'h0, 1'b0},
    {1'b1, 4'b0100, 1'b0, 5'b01000, 4'h4, 1'b0},
    {1'b0, 4'b1111, 1'b0, 5'b11100, 4'h4, 1'b0},
    {1'b0, 4'b0011, 1'b0, 5'b01100, 4'h4, 1'b0},
    {1'b0, 4'b0111, 1'b0, 5'b01100, 4'h4, 1'b0},
    {1'b1, 4'b1011, 1'b0, 5'b01100, 4'hB, 1'b0},
    {1'b0, 4'b1111, 1'b0, 5'b11100, 4'hB, 1'b0}
  };

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pipe_pid = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic count_sof(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sof_strobe) c++;
    end
  endtask

  task automatic pulse_dtch();
    @(negedge clk);
    dtch_pulse = 1'b1;
    @(negedge clk);
    dtch_pulse = 1'b0;
  endtask

  task automatic run_to(logic [3:0] code);
    wr(1'b0, 4'b0011);
    wr(1'b0, 4'b0111);
    wr(1'b1, code);
    wr(1'b0, 4'b1111);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", "sel", sel_out, 0);
    chk("R1", "outputs", {wave_en, hs_term_en, sof_strobe, dtch_irq, seq_err, nak_err, test_locked}, 0);
    rst_n = 1'b1;

    // Table walk: R2 R4 R5 R6 R12 setup, selector change
    for (int i = 0; i < 8; i++) begin
      pipe_pid = VEC[i][10] ? 6'b000100 : 6'b000000;
      wr(VEC[i][15], VEC[i][14:11]);
      chk("R2/R6", $sformatf("vec%0d sel", i), sel_out, VEC[i][4:1]);
      chk("R4", $sformatf("vec%0d wave", i), wave_en, VEC[i][9]);
      chk("R5", $sformatf("vec%0d term", i), hs_term_en, VEC[i][8]);
      chk("R12", $sformatf("vec%0d locked", i), test_locked, VEC[i][7]);
      chk("R2", $sformatf("vec%0d seq_err", i), seq_err, VEC[i][6]);
      chk("R7", $sformatf("vec%0d nak_err", i), nak_err, VEC[i][5]);
    end

    // R9: SE0/NAK code gives no SOF
    count_sof(40, c);
    chk("R9", "sof count", c, 0);

    // R10: force-enable code, SOF runs and disconnect ignored
    wr(1'b0, 4'b0011); wr(1'b0, 4'b0111); wr(1'b1, 4'b1101); wr(1'b0, 4'b1111);
    chk("R6", "sel after change", sel_out, 13);
    count_sof(40, c);
    chk("R10", "sof count force", c, 5);
    pulse_dtch();
    chk("R10", "irq", dtch_irq, 0);
    @(negedge clk);
    chk("R10", "irq later", dtch_irq, 0);
    chk("R10", "wave kept", wave_en, 1);

    // R11: other code, disconnect clears activate
    do_reset();
    chk("R1", "locked after reset", test_locked, 0);
    run_to(4'b0100);
    count_sof(40, c);
    chk("R8", "sof count", c, 5);
    pulse_dtch();
    chk("R11", "irq", dtch_irq, 1);
    chk("R11", "wave cleared", wave_en, 0);
    @(negedge clk);
    chk("R11", "irq one cycle", dtch_irq, 0);
    count_sof(20, c);
    chk("R8", "no sof when inactive", c, 0);
    wr(1'b0, 4'b1111);
    chk("R11", "re-activate", wave_en, 1);
    chk("R11", "no seq_err", seq_err, 0);
    count_sof(PER - 1, c);
    chk("R8", "first strobe delay", c, 0);
    count_sof(1, c);
    chk("R8", "first strobe", c, 1);

    // R12: clearing bits locks
    wr(1'b0, 4'b0000);
    chk("R12", "wave off", wave_en, 0);
    chk("R12", "locked", test_locked, 1);
    chk("R12", "no err on clear", seq_err, 0);
    wr(1'b0, 4'b0011);
    chk("R12", "locked rejects", seq_err, 1);
    chk("R12", "still locked", test_locked, 1);
    wr(1'b0, 4'b0111);
    chk("R12", "no enable", wave_en, 0);

    // R3: selector write before enable step
    do_reset();
    wr(1'b1, 4'b0110);
    chk("R3", "seq_err", seq_err, 1);
    chk("R3", "sel kept", sel_out, 0);
    chk("R3", "term off", hs_term_en, 0);
    do_reset();
    wr(1'b0, 4'b0011);
    wr(1'b1, 4'b0110);
    chk("R3", "sel before enable", sel_out, 0);
    chk("R3", "seq_err prep", seq_err, 1);

    // R2: skipping a step
    do_reset();
    wr(1'b0, 4'b1111);
    chk("R2", "skip seq_err", seq_err, 1);
    chk("R2", "skip wave", wave_en, 0);
    chk("R2", "skip locked", test_locked, 0);

    // R7: pipe not NAK
    do_reset();
    wr(1'b0, 4'b0011);
    wr(1'b0, 4'b0111);
    pipe_pid = 6'b000100;
    wr(1'b1, 4'b0100);
    chk("R7", "nak_err", nak_err, 1);
    chk("R7", "sel kept", sel_out, 0);
    chk("R7", "term off", hs_term_en, 0);
    chk("R7", "no seq_err", seq_err, 0);
    pipe_pid = 6'b000000;
    wr(1'b1, 4'b0100);
    chk("R7", "sel after NAK", sel_out, 4);
    chk("R5", "term on", hs_term_en, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule